// File: doc/BRIEF.md
# Timer Interrupt Status Unit

This unit holds the interrupt status of a group of timer channels. Each channel offers two event sources, a time-out pulse and a match pulse. A pulse latches into a sticky raw status bit. Software clears that bit by writing a 1 to the same bit position of a clear register. A mask register chooses which raw bits reach the masked status, and a single interrupt line is raised while any masked bit is set.

The two sources are gated in opposite ways. A time-out pulse sets its raw bit unless a per-channel disable input is high. A match pulse touches its raw bit only while a per-channel enable input is high. The event pulses and the configuration bits come from the timer core. The registers are reached through a simple single-cycle read/write port.

The status word places channel c's time-out source at bit 2c and its match source at bit 2c+1. All three status registers and the clear register use this same layout. Register select: 0 raw status (read-only), 1 mask (read/write), 2 masked status (read-only), 3 clear (write-only). Reads are combinational, and bits above the source count read as 0.

Top module: `tmr_irq_status`

## Requirements
- R1: A time-out pulse on channel c while its disable input is low sets raw bit 2c at the next rising clock edge.
- R2: A set raw bit stays set until a write to select 3 carries a 1 in that bit position; a 0 in that position of a clear write leaves the bit unchanged.
- R3: While channel c's time-out disable input is high, time-out pulses never set raw bit 2c.
- R4: A match pulse on channel c sets raw bit 2c+1 only while its enable input is high; with the enable low, match pulses leave that bit unchanged.
- R5: The match bit 2c+1 is cleared through bit 2c+1 of the clear register and masked through bit 2c+1 of the mask register, independently of the time-out bit.
- R6: When a source's event pulse and a clear write hitting its bit occur in the same cycle, the raw bit ends up set.
- R7: Reading select 2 returns the bitwise AND of the raw status and the mask register.
- R8: The interrupt output is high exactly when at least one masked status bit is set.
- R9: A write to select 1 loads the mask, which reads back unchanged from select 1; reading select 3 always returns 0.
- R10: After reset the raw status and the mask are all zero and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| to_evt_i | input | N_CH | Time-out event pulses, one per channel |
| mt_evt_i | input | N_CH | Match event pulses, one per channel |
| to_irq_dis_i | input | N_CH | Per-channel time-out status disable |
| mt_irq_en_i | input | N_CH | Per-channel match status enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational) |
| irq_o | output | 1 | Combined interrupt line |

## Verification
A raw bit stuck at the wrong value shows on the raw status read in the cycle right after the offending edge. If that bit is unmasked, it also shows on the interrupt line in that cycle. A mask register that loses or corrupts a bit shows on the mask read-back, and it hides or adds a bit in the masked read and on the interrupt line from the next edge onward. Gating faults, such as a disabled time-out that still sets or a disabled match that still changes, show only after a pulse arrives while the gate is closed. The bench therefore drives pulses in exactly that condition and reads all status registers after every step.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int unsigned REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    SEL_RAW    = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_MASKED = 2'd2,
    SEL_CLEAR  = 2'd3
  } reg_sel_e;

  // how the per-source option input gates the set path
  typedef enum logic {
    GATE_OPT_OUT = 1'b0,  // sets unless option high
    GATE_OPT_IN  = 1'b1   // sets only while option high
  } gate_kind_e;
endpackage

// File: rtl/tmr_irq_src.sv
module tmr_irq_src
  import tmr_irq_pkg::*;
#(
  parameter gate_kind_e KIND = GATE_OPT_OUT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic opt_i,
  input  logic clr_i,
  output logic raw_o
);
  logic set_ok;
  logic raw_q;

  generate
    if (KIND == GATE_OPT_OUT) begin : g_opt_out
      assign set_ok = evt_i & ~opt_i;
    end else begin : g_opt_in
      assign set_ok = evt_i & opt_i;
    end
  endgenerate

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      raw_q <= 1'b0;
    else if (set_ok)  raw_q <= 1'b1;
    else if (clr_i)   raw_q <= 1'b0;
  end

  assign raw_o = raw_q;
endmodule

// File: rtl/tmr_irq_regs.sv
module tmr_irq_regs
  import tmr_irq_pkg::*;
#(
  parameter int unsigned NSRC   = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NSRC-1:0]   raw_i,
  output logic [NSRC-1:0]   clr_o,
  output logic [NSRC-1:0]   mask_o,
  output logic [NSRC-1:0]   masked_o,
  output logic [DATA_W-1:0] rdata_o
);
  reg_sel_e        sel;
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] wr_bits;

  assign sel     = reg_sel_e'(addr_i);
  assign wr_bits = wdata_i[NSRC-1:0];

  generate
    if (DATA_W > NSRC) begin : g_hi
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^wdata_i[DATA_W-1:NSRC];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        mask_q <= '0;
    else if (we_i && sel == SEL_MASK)   mask_q <= wr_bits;
  end

  assign clr_o    = (we_i && sel == SEL_CLEAR) ? wr_bits : '0;
  assign mask_o   = mask_q;
  assign masked_o = raw_i & mask_q;

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_RAW:    rdata_o[NSRC-1:0] = raw_i;
      SEL_MASK:   rdata_o[NSRC-1:0] = mask_q;
      SEL_MASKED: rdata_o[NSRC-1:0] = raw_i & mask_q;
      SEL_CLEAR:  rdata_o = '0;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tmr_irq_status.sv
module tmr_irq_status
  import tmr_irq_pkg::*;
#(
  parameter int unsigned N_CH   = 2,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   to_evt_i,
  input  logic [N_CH-1:0]   mt_evt_i,
  input  logic [N_CH-1:0]   to_irq_dis_i,
  input  logic [N_CH-1:0]   mt_irq_en_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int unsigned NSRC = 2 * N_CH;

  logic [NSRC-1:0] raw_q;
  logic [NSRC-1:0] clr_bits;
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] masked;

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      tmr_irq_src #(.KIND(GATE_OPT_OUT)) u_to (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .evt_i (to_evt_i[c]),
        .opt_i (to_irq_dis_i[c]),
        .clr_i (clr_bits[2*c]),
        .raw_o (raw_q[2*c])
      );
      tmr_irq_src #(.KIND(GATE_OPT_IN)) u_mt (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .evt_i (mt_evt_i[c]),
        .opt_i (mt_irq_en_i[c]),
        .clr_i (clr_bits[2*c+1]),
        .raw_o (raw_q[2*c+1])
      );
    end
  endgenerate

  tmr_irq_regs #(.NSRC(NSRC), .DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .raw_i   (raw_q),
    .clr_o   (clr_bits),
    .mask_o  (mask_q),
    .masked_o(masked),
    .rdata_o (reg_rdata_o)
  );

  assign irq_o = |masked;
endmodule

// File: rtl/tmr_irq_status_chk.sv
module tmr_irq_status_chk
  import tmr_irq_pkg::*;
#(
  parameter int unsigned N_CH   = 2,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NSRC  = 2 * N_CH
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_CH-1:0]   to_evt_i,
  input logic [N_CH-1:0]   mt_evt_i,
  input logic [N_CH-1:0]   to_irq_dis_i,
  input logic [N_CH-1:0]   mt_irq_en_i,
  input logic              reg_we_i,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic [NSRC-1:0]   wbits_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              irq_o,
  input logic [NSRC-1:0]   raw_q
);
  logic clr_wr;
  assign clr_wr = reg_we_i && (reg_addr_i == SEL_CLEAR);

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      // R1
      to_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        to_evt_i[c] && !to_irq_dis_i[c] |=> raw_q[2*c]);
      // R3
      to_dis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        to_irq_dis_i[c] && !raw_q[2*c] |=> !raw_q[2*c]);
      // R4
      mt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mt_irq_en_i[c] && !(clr_wr && wbits_i[2*c+1]) |=> $stable(raw_q[2*c+1]));
      // R6
      mt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mt_evt_i[c] && mt_irq_en_i[c] |=> raw_q[2*c+1]);
    end
    for (genvar b = 0; b < NSRC; b++) begin : g_bit
      // R2
      raw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        raw_q[b] && !(clr_wr && wbits_i[b]) |=> raw_q[b]);
    end
  endgenerate

  // R8
  irq_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr && (&wbits_i) && !(|to_evt_i) && !(|mt_evt_i) |=> !irq_o);
  // R9
  clr_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_addr_i == SEL_CLEAR |-> reg_rdata_o == '0);
endmodule

bind tmr_irq_status tmr_irq_status_chk #(.N_CH(N_CH), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .to_evt_i    (to_evt_i),
  .mt_evt_i    (mt_evt_i),
  .to_irq_dis_i(to_irq_dis_i),
  .mt_irq_en_i (mt_irq_en_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .wbits_i     (reg_wdata_i[2*N_CH-1:0]),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .raw_q       (raw_q)
);

// File: tb/sim_tmr_irq_status.sv
module sim_tmr_irq_status;
  localparam int CLK_PERIOD = 10;
  localparam int N_CH = 2;
  localparam int DW   = 32;
  localparam int NS   = 2 * N_CH;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N_CH-1:0] to_evt = '0, mt_evt = '0, to_dis = '0, mt_en = '0;
  logic          we = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [DW-1:0] d;
    logic          irq;
    string         tag;
  } item_t;
  item_t sb_q[$];
  event  smp;

  logic [NS-1:0] m_raw  = '0;
  logic [NS-1:0] m_mask = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_irq_status #(.N_CH(N_CH), .DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .to_evt_i(to_evt), .mt_evt_i(mt_evt),
    .to_irq_dis_i(to_dis), .mt_irq_en_i(mt_en),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  // monitor: pops expected items and compares
  initial begin
    forever begin
      @(smp);
      if (sb_q.size() != 0) begin
        item_t it;
        it = sb_q.pop_front();
        total++;
        if (rdata !== it.d || irq !== it.irq) begin
          bad++;
          $display("FAIL %s sel=%0d rdata=%h exp=%h irq=%b exp=%b",
                   it.tag, addr, rdata, it.d, irq, it.irq);
        end
      end
    end
  end

  task automatic rd(input logic [1:0] a, input logic [NS-1:0] e, input string tag);
    item_t it;
    addr = a;
    it.d = '0;
    it.d[NS-1:0] = e;
    it.irq = |(m_raw & m_mask);
    it.tag = tag;
    sb_q.push_back(it);
    #1;
    ->smp;
    #1;
  endtask

  task automatic check_all(input string tag);
    rd(2'd0, m_raw, tag);
    rd(2'd1, m_mask, tag);
    rd(2'd2, m_raw & m_mask, tag);
    rd(2'd3, '0, tag);
  endtask

  // driver: one clocked operation, model updated from the requirements
  task automatic step(input logic [N_CH-1:0] te, input logic [N_CH-1:0] me,
                      input logic w, input logic [1:0] a, input logic [NS-1:0] wd,
                      input string tag);
    @(negedge clk);
    to_evt = te; mt_evt = me; we = w; addr = a; wdata = '0; wdata[NS-1:0] = wd;
    for (int c = 0; c < N_CH; c++) begin
      if (te[c] && !to_dis[c])              m_raw[2*c] = 1'b1;
      else if (w && a == 2'd3 && wd[2*c])   m_raw[2*c] = 1'b0;
      if (me[c] && mt_en[c])                m_raw[2*c+1] = 1'b1;
      else if (w && a == 2'd3 && wd[2*c+1]) m_raw[2*c+1] = 1'b0;
    end
    if (w && a == 2'd1) m_mask = wd;
    @(posedge clk);
    #1;
    to_evt = '0; mt_evt = '0; we = 1'b0; wdata = '0;
    check_all(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_all("R10 during reset");
    rst_n = 1'b1;
    @(posedge clk); #1;
    check_all("R10 after reset");

    step('0, '0, 1'b1, 2'd1, 4'b0101, "R9 mask write");
    step(2'b01, '0, 1'b0, 2'd0, '0, "R1 R8 time-out ch0");
    step('0, '0, 1'b1, 2'd3, 4'b0000, "R2 clear with zeros");
    step('0, '0, 1'b1, 2'd0, 4'b1111, "R2 write to raw select");
    step('0, '0, 1'b0, 2'd0, '0, "R2 idle hold");
    step('0, '0, 1'b1, 2'd3, 4'b0001, "R2 clear bit0");
    step(2'b10, '0, 1'b0, 2'd0, '0, "R1 time-out ch1");
    step('0, '0, 1'b1, 2'd3, 4'b0100, "R2 clear bit2");
    to_dis = 2'b10;
    step(2'b10, '0, 1'b0, 2'd0, '0, "R3 disabled time-out");
    step(2'b11, '0, 1'b0, 2'd0, '0, "R3 mixed disable");
    to_dis = 2'b00;
    step('0, '0, 1'b1, 2'd3, 4'b0001, "R2 clear bit0 again");
    step('0, 2'b01, 1'b0, 2'd0, '0, "R4 match with enable low");
    mt_en = 2'b01;
    step('0, 2'b01, 1'b0, 2'd0, '0, "R4 R7 match enabled, masked off");
    step('0, '0, 1'b1, 2'd1, 4'b1111, "R8 R9 unmask all");
    mt_en = 2'b00;
    step('0, '0, 1'b1, 2'd3, 4'b0010, "R5 clear match bit1");
    mt_en = 2'b10;
    step('0, 2'b10, 1'b0, 2'd0, '0, "R5 match ch1");
    mt_en = 2'b00;
    step('0, 2'b10, 1'b1, 2'd3, 4'b0001, "R4 match held with enable low");
    step(2'b01, '0, 1'b1, 2'd3, 4'b0001, "R6 event and clear same cycle");
    step('0, '0, 1'b1, 2'd1, 4'b0010, "R7 R5 mask only bit1");
    step('0, '0, 1'b1, 2'd3, 4'b1111, "R8 clear all");
    step('0, '0, 1'b1, 2'd2, 4'b1111, "R7 write to masked select");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule